// File: doc/BRIEF.md
# Table-Driven Radix Multiplier with Shared Adder Datapath

The block multiplies one stored unsigned multiplicand by a stream of unsigned multipliers. Loading a multiplicand starts a short build phase. In this phase a register table is filled with the multiplicand times every value a T-bit digit can take. Each entry is the previous entry plus the multiplicand, so no hardware multiplier is used. Each multiplier is then cut into N/T digits. Each digit selects one table entry, and the selected entries are weighted by their digit position and summed in an adder tree to give the 2N-bit product. The table stays valid for any number of later multipliers, which suits a matrix-vector loop where one coefficient meets many vector elements.

The path is a two-stage pipeline: the first stage registers the weighted terms and the second adds them and registers the result. One operation is accepted per cycle whenever ready is high. A mode input sent with each operation turns the same terms and adder tree into a plain adder, a subtractor or an accumulator. Loading a new multiplicand never disturbs operations that were accepted earlier.

Top module: `radix_table_mul`

## Requirements
- R1: After reset op_ready_o is 1 and res_valid_o is 0, and the table holds the multiples of a zero multiplicand, so a multiply returns 0 until a multiplicand is loaded.
- R2: In mode 2'b00 (multiply) the result is the full 2N-bit unsigned product of the stored multiplicand and op_a_i; op_b_i is ignored.
- R3: A cycle with load_i high stores mcand_i and starts a table build; op_ready_o is 0 for exactly 2^T-1 cycles after that cycle, and op_valid_i during those cycles is not accepted and produces no result.
- R4: Once built, the table serves every later multiply without a rebuild: op_ready_o stays 1 across back-to-back multiplies.
- R5: An operation accepted in cycle k (op_valid_i and op_ready_o both 1) shows up with res_valid_o high in cycle k+2 and at no other time; one operation can be accepted every cycle.
- R6: In mode 2'b01 (add) the result is op_a_i + op_b_i, zero-extended to 2N bits.
- R7: In mode 2'b10 (subtract) the result is op_a_i - op_b_i modulo 2^(2N).
- R8: In mode 2'b11 (accumulate) the accumulator gains op_a_i modulo 2^(2N), and the result is the new accumulator value.
- R9: acc_clr_i high sets the accumulator to 0 at the next clock edge; the next accumulate then returns just its own op_a_i.
- R10: An operation accepted before a load, or in the same cycle as it, uses the previous multiplicand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Store mcand_i and rebuild the table |
| mcand_i | input | N | Multiplicand |
| mode_i | input | 2 | 00 multiply, 01 add, 10 subtract, 11 accumulate |
| acc_clr_i | input | 1 | Clear the accumulator |
| op_valid_i | input | 1 | Operation offered |
| op_ready_o | output | 1 | Operation can be accepted (table is built) |
| op_a_i | input | N | Multiplier, or first operand |
| op_b_i | input | N | Second operand for add and subtract |
| res_valid_o | output | 1 | Result valid |
| res_o | output | 2N | Product, sum, difference or accumulator value |

## Verification
The bench builds the block with N=16 and T=4. This gives a 16-entry table, four digits and a 15-cycle build window. All-ones multipliers and multiplicands therefore reach the last table entry in every digit and the top bits of the 32-bit product. Because the operand is 16 bits wide, a run of 65540 accumulations of 0xFFFF is enough to pass 2^32 and exercise the modulo wrap of the accumulator. Loads are placed while multiplies are still in the pipeline, and also in the same cycle as an accepted multiply, so that the old table must still be used.

// File: rtl/rtm_pkg.sv
package rtm_pkg;
  typedef enum logic [1:0] {
    OP_MUL = 2'd0,
    OP_ADD = 2'd1,
    OP_SUB = 2'd2,
    OP_ACC = 2'd3
  } op_mode_e;
endpackage

// File: rtl/rtm_table.sv
module rtm_table #(
  parameter int N = 16,
  parameter int T = 4,
  localparam int ENT = 1 << T,
  localparam int EW  = N + T
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   load_i,
  input  logic [N-1:0]           mcand_i,
  output logic                   busy_o,
  output logic [ENT-1:0][EW-1:0] tbl_o
);
  logic [N-1:0]           mcand_q;
  logic [T-1:0]           cnt_q;
  logic                   busy_q;
  logic [ENT-1:0][EW-1:0] tbl_q;

  // one new multiple per cycle: entry[i] = entry[i-1] + mcand
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mcand_q <= '0;
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      tbl_q   <= '0;
    end else if (load_i) begin
      mcand_q <= mcand_i;
      cnt_q   <= T'(1);
      busy_q  <= 1'b1;
    end else if (busy_q) begin
      tbl_q[cnt_q] <= tbl_q[T'(cnt_q - T'(1))] + EW'(mcand_q);
      cnt_q        <= cnt_q + T'(1);
      if (cnt_q == T'(ENT - 1)) busy_q <= 1'b0;
    end
  end

  assign busy_o = busy_q;
  assign tbl_o  = tbl_q;

  // R3
  load_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> busy_o);

  // R3
  tbl_top_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> tbl_q[ENT-1] == EW'(mcand_q) * EW'(ENT - 1));
endmodule

// File: rtl/rtm_select.sv
module rtm_select
  import rtm_pkg::*;
#(
  parameter int N = 16,
  parameter int T = 4,
  localparam int NDIG = N / T,
  localparam int ENT  = 1 << T,
  localparam int EW   = N + T,
  localparam int PW   = 2 * N
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    accept_i,
  input  op_mode_e                mode_i,
  input  logic [N-1:0]            a_i,
  input  logic [N-1:0]            b_i,
  input  logic [ENT-1:0][EW-1:0]  tbl_i,
  output logic                    vld_o,
  output op_mode_e                mode_o,
  output logic [NDIG-1:0][PW-1:0] terms_o
);
  logic [NDIG-1:0][PW-1:0] term_d;

  for (genvar k = 0; k < NDIG; k++) begin : g_dig
    logic [T-1:0]  dig;
    logic [PW-1:0] prod_term;
    logic [PW-1:0] alt_term;
    assign dig       = a_i[k*T +: T];
    assign prod_term = PW'(tbl_i[dig]) << (T * k);
    if (k == 0) begin : g_a
      assign alt_term = PW'(a_i);
    end else if (k == 1) begin : g_b
      always_comb begin
        case (mode_i)
          OP_ADD:  alt_term = PW'(b_i);
          OP_SUB:  alt_term = PW'(0) - PW'(b_i);
          default: alt_term = '0;
        endcase
      end
    end else begin : g_zero
      assign alt_term = '0;
    end
    assign term_d[k] = (mode_i == OP_MUL) ? prod_term : alt_term;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o   <= 1'b0;
      mode_o  <= OP_MUL;
      terms_o <= '0;
    end else begin
      vld_o <= accept_i;
      if (accept_i) begin
        mode_o  <= mode_i;
        terms_o <= term_d;
      end
    end
  end
endmodule

// File: rtl/rtm_sum_tree.sv
module rtm_sum_tree #(
  parameter int CNT = 4,
  parameter int W   = 32,
  localparam int LV = (CNT > 1) ? $clog2(CNT) : 1,
  localparam int P  = 1 << LV
) (
  input  logic [CNT-1:0][W-1:0] in_i,
  output logic [W-1:0]          sum_o
);
  for (genvar l = 0; l <= LV; l++) begin : g_lvl
    localparam int C = P >> l;
    logic [C-1:0][W-1:0] v;
    if (l == 0) begin : g_leaf
      for (genvar i = 0; i < C; i++) begin : g_in
        if (i < CNT) begin : g_used
          assign v[i] = in_i[i];
        end else begin : g_pad
          assign v[i] = '0;
        end
      end
    end else begin : g_add
      for (genvar i = 0; i < C; i++) begin : g_pair
        assign v[i] = g_lvl[l-1].v[2*i] + g_lvl[l-1].v[2*i+1];
      end
    end
  end

  assign sum_o = g_lvl[LV].v[0];
endmodule

// File: rtl/rtm_accum.sv
module rtm_accum
  import rtm_pkg::*;
#(
  parameter int PW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          vld_i,
  input  op_mode_e      mode_i,
  input  logic [PW-1:0] sum_i,
  input  logic          clr_i,
  output logic          res_vld_o,
  output logic [PW-1:0] res_o
);
  logic [PW-1:0] acc_q;
  logic [PW-1:0] total;

  assign total = sum_i + ((mode_i == OP_ACC) ? acc_q : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_vld_o <= 1'b0;
      res_o     <= '0;
      acc_q     <= '0;
    end else begin
      res_vld_o <= vld_i;
      if (vld_i) res_o <= total;
      if (clr_i) acc_q <= '0;
      else if (vld_i && mode_i == OP_ACC) acc_q <= total;
    end
  end

  // R9
  acc_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> acc_q == '0);
endmodule

// File: rtl/radix_table_mul.sv
module radix_table_mul
  import rtm_pkg::*;
#(
  parameter int N = 16,
  parameter int T = 4,
  localparam int NDIG = N / T,
  localparam int ENT  = 1 << T,
  localparam int EW   = N + T,
  localparam int PW   = 2 * N
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [N-1:0]  mcand_i,
  input  logic [1:0]    mode_i,
  input  logic          acc_clr_i,
  input  logic          op_valid_i,
  output logic          op_ready_o,
  input  logic [N-1:0]  op_a_i,
  input  logic [N-1:0]  op_b_i,
  output logic          res_valid_o,
  output logic [PW-1:0] res_o
);
  logic                    busy;
  logic [ENT-1:0][EW-1:0]  tbl;
  logic                    accept;
  logic                    s1_vld;
  op_mode_e                s1_mode;
  logic [NDIG-1:0][PW-1:0] s1_terms;
  logic [PW-1:0]           tree_sum;

  assign op_ready_o = !busy;
  assign accept     = op_valid_i && op_ready_o;

  rtm_table #(.N(N), .T(T)) u_table (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load_i),
    .mcand_i (mcand_i),
    .busy_o  (busy),
    .tbl_o   (tbl)
  );

  rtm_select #(.N(N), .T(T)) u_select (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .accept_i (accept),
    .mode_i   (op_mode_e'(mode_i)),
    .a_i      (op_a_i),
    .b_i      (op_b_i),
    .tbl_i    (tbl),
    .vld_o    (s1_vld),
    .mode_o   (s1_mode),
    .terms_o  (s1_terms)
  );

  rtm_sum_tree #(.CNT(NDIG), .W(PW)) u_tree (
    .in_i  (s1_terms),
    .sum_o (tree_sum)
  );

  rtm_accum #(.PW(PW)) u_accum (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .vld_i     (s1_vld),
    .mode_i    (s1_mode),
    .sum_i     (tree_sum),
    .clr_i     (acc_clr_i),
    .res_vld_o (res_valid_o),
    .res_o     (res_o)
  );

  // R5
  res_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |-> ##2 res_valid_o);

  // R5
  res_origin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> $past(accept, 2));
endmodule

// File: tb/radix_table_mul_bench.sv
`timescale 1ns/1ps
module radix_table_mul_bench;
  localparam int N  = 16;
  localparam int T  = 4;
  localparam int PW = 2 * N;
  localparam int BUILD = (1 << T) - 1;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          load_i = 1'b0;
  logic [N-1:0]  mcand_i = '0;
  logic [1:0]    mode_i = 2'd0;
  logic          acc_clr_i = 1'b0;
  logic          op_valid_i = 1'b0;
  logic          op_ready_o;
  logic [N-1:0]  op_a_i = '0;
  logic [N-1:0]  op_b_i = '0;
  logic          res_valid_o;
  logic [PW-1:0] res_o;

  int checks = 0;
  int errors = 0;
  int cyc_n  = 0;
  bit done   = 1'b0;
  string cur_tag = "";

  logic [N-1:0]  model_mcand = '0;
  logic [PW-1:0] model_acc   = '0;
  int            due_q[$];
  logic [PW-1:0] val_q[$];
  string         tag_q[$];

  always #2 clk_i = ~clk_i;

  radix_table_mul u_radix_table_mul (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .mcand_i(mcand_i),
    .mode_i(mode_i), .acc_clr_i(acc_clr_i), .op_valid_i(op_valid_i),
    .op_ready_o(op_ready_o), .op_a_i(op_a_i), .op_b_i(op_b_i),
    .res_valid_o(res_valid_o), .res_o(res_o)
  );

  task automatic check(input bit ok, input string tag, input logic [PW-1:0] act,
                       input logic [PW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [PW-1:0] f_expect(input logic [1:0] m, input logic [N-1:0] mc,
                                             input logic [N-1:0] a, input logic [N-1:0] b);
    case (m)
      2'd0:    return PW'(mc) * PW'(a);
      2'd1:    return PW'(a) + PW'(b);
      default: return PW'(a) - PW'(b);
    endcase
  endfunction

  function automatic string f_tag(input logic [1:0] m);
    case (m)
      2'd0: return "R2";
      2'd1: return "R6";
      2'd2: return "R7";
      default: return "R8";
    endcase
  endfunction

  // scoreboard: checks outputs, then records the operation accepted at the coming edge
  always @(negedge clk_i) begin
    if (rst_ni) begin
      cyc_n++;
      if (res_valid_o) begin
        if (due_q.size() == 0 || due_q[0] != cyc_n) begin
          check(1'b0, "R5 unexpected result", res_o, '0);
        end else begin
          check(res_o == val_q[0], tag_q[0], res_o, val_q[0]);
          void'(due_q.pop_front()); void'(val_q.pop_front()); void'(tag_q.pop_front());
        end
      end else if (due_q.size() != 0 && due_q[0] == cyc_n) begin
        check(1'b0, "R5 missing result", '0, val_q[0]);
        void'(due_q.pop_front()); void'(val_q.pop_front()); void'(tag_q.pop_front());
      end
      if (op_valid_i && op_ready_o) begin
        logic [PW-1:0] e;
        if (mode_i == 2'd3) begin
          model_acc = model_acc + PW'(op_a_i);
          e = model_acc;
        end else begin
          e = f_expect(mode_i, model_mcand, op_a_i, op_b_i);
        end
        due_q.push_back(cyc_n + 2);
        val_q.push_back(e);
        tag_q.push_back(cur_tag.len() != 0 ? cur_tag : f_tag(mode_i));
      end
      if (load_i) model_mcand = mcand_i;
      if (acc_clr_i) model_acc = '0;
    end
  end

  task automatic cyc();
    @(posedge clk_i);
    #1;
  endtask

  task automatic op(input logic [1:0] m, input logic [N-1:0] a, input logic [N-1:0] b);
    op_valid_i = 1'b1; mode_i = m; op_a_i = a; op_b_i = b;
    cyc();
  endtask

  task automatic idle(input int n);
    op_valid_i = 1'b0; load_i = 1'b0; acc_clr_i = 1'b0;
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic load_and_wait(input logic [N-1:0] mc);
    load_i = 1'b1; mcand_i = mc;
    cyc();
    load_i = 1'b0;
    while (!op_ready_o) cyc();
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    #10;
    rst_ni = 1'b1;
    cyc();
    // R1 reset state
    check(op_ready_o == 1'b1, "R1 ready after reset", PW'(op_ready_o), 1);
    check(res_valid_o == 1'b0, "R1 no result after reset", PW'(res_valid_o), 0);
    cur_tag = "R1";
    op(2'd0, 16'h1234, 16'h0);
    op(2'd0, 16'hFFFF, 16'h0);
    idle(3);

    // R3 build window: ready low exactly BUILD cycles, offers ignored
    cur_tag = "";
    load_i = 1'b1; mcand_i = 16'hBEEF;
    cyc();
    load_i = 1'b0;
    op_valid_i = 1'b1; mode_i = 2'd0; op_a_i = 16'h0101;
    for (int i = 0; i < BUILD; i++) begin
      check(op_ready_o == 1'b0, "R3 ready low during build", PW'(op_ready_o), 0);
      check(res_valid_o == 1'b0, "R3 offer during build ignored", PW'(res_valid_o), 0);
      cyc();
    end
    op_valid_i = 1'b0;
    check(op_ready_o == 1'b1, "R3 ready after build", PW'(op_ready_o), 1);
    idle(3);
    check(res_valid_o == 1'b0, "R3 no result from ignored offers", PW'(res_valid_o), 0);

    // R2 and R4 directed multipliers back to back
    cur_tag = "R2";
    begin
      logic [N-1:0] dir[6] = '{16'h0000, 16'hFFFF, 16'h000F, 16'hF000, 16'h1234, 16'h8001};
      for (int i = 0; i < 6; i++) begin
        op(2'd0, dir[i], 16'hAAAA);
        check(op_ready_o == 1'b1, "R4 ready stays high", PW'(op_ready_o), 1);
      end
    end
    idle(3);
    load_and_wait(16'hFFFF);
    op(2'd0, 16'hFFFF, 16'h0);
    op(2'd0, 16'h0001, 16'h0);
    idle(3);

    // R10 load while multiplies in flight, including the same cycle
    cur_tag = "R10";
    load_and_wait(16'h0123);
    op(2'd0, 16'h4567, 16'h0);
    load_i = 1'b1; mcand_i = 16'h7777;
    op(2'd0, 16'h89AB, 16'h0);
    load_i = 1'b0; op_valid_i = 1'b0;
    while (!op_ready_o) cyc();
    cur_tag = "R2";
    op(2'd0, 16'h89AB, 16'h0);
    idle(3);

    // R6 R7 directed
    cur_tag = "R6";
    op(2'd1, 16'hFFFF, 16'hFFFF);
    op(2'd1, 16'h0000, 16'h0000);
    cur_tag = "R7";
    op(2'd2, 16'h0003, 16'h0005);
    op(2'd2, 16'hFFFF, 16'h0001);
    idle(3);

    // R9 clear, then accumulate returns its own operand
    acc_clr_i = 1'b1; cyc(); acc_clr_i = 1'b0;
    cur_tag = "R9";
    op(2'd3, 16'h0005, 16'h0);
    cur_tag = "R8";
    op(2'd3, 16'h0007, 16'h0);
    idle(3);

    // R8 accumulator wraps past 2^32
    acc_clr_i = 1'b1; cyc(); acc_clr_i = 1'b0;
    for (int i = 0; i < 65540; i++) op(2'd3, 16'hFFFF, 16'h0);
    idle(3);
    acc_clr_i = 1'b1; cyc(); acc_clr_i = 1'b0;
    cur_tag = "R9";
    op(2'd3, 16'h0042, 16'h0);
    idle(3);

    // random mix
    cur_tag = "";
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 39) == 0) begin
        idle(3);
        load_and_wait(16'($urandom()));
      end
      while (!op_ready_o) begin op_valid_i = 1'b0; cyc(); end
      op($urandom_range(0, 4) > 2'd3 ? 2'($urandom_range(1, 3)) : 2'($urandom_range(0, 3)),
         16'($urandom()), 16'($urandom()));
      if ($urandom_range(0, 3) == 0) idle(1);
    end
    idle(4);
    check(due_q.size() == 0, "R5 all results delivered", PW'(due_q.size()), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule